// File: doc/BRIEF.md
# Video Unit CPU Register Port

This block is the processor-side register interface of a tile-based video unit. A processor reaches eight byte-wide ports, chosen by a three-bit port number. Behind those ports sit four registers:

- a control byte;
- a mask byte;
- three status flags;
- a sprite attribute memory of 256 bytes with its own address pointer.

The same ports also reach the scroll and address state used by the renderer: a temporary address with a separate fine horizontal offset, and a current video-memory address. Two of the ports take their values as pairs of byte writes, and both pairs share a single write toggle.

Data-port accesses go out to video memory through a request/acknowledge handshake. Reads below the palette region return what the previous read fetched, one access late. Reads in the palette region return the fetched entry at once. A bus latch keeps the last value seen on the data bus. Status reads and reads of write-only ports show that latch. It clears to zero after a parameterised number of idle cycles.

Processor accesses hold `cpu_req` until `cpu_ack`, which lasts exactly one cycle and carries the read data. The controller is a three-state machine:

- IDLE waits for a request. It carries out register ports at once and then takes transition IDLE->DONE. For the data port it takes transition IDLE->VMEM.
- VMEM drives the video-memory request. It stays there (VMEM->VMEM) until `vm_ack`, then takes VMEM->DONE. That same edge captures the read data, refills the buffer and steps the current address.
- DONE raises `cpu_ack` for one cycle and returns by DONE->IDLE.

Top module: `vid_regport`

## Requirements
- R1: After reset the control, mask, temporary address, current address, fine X and sprite pointer are zero. The three status flags, the write toggle, the read buffer and the bus latch are clear, and `cpu_ack` and `vm_req` are low.
- R2: A write to port 0 loads `ctrl_o` and copies data bits 1:0 into temporary address bits 11:10. A write to port 1 loads `mask_o`. Neither write changes the toggle.
- R3: A read of port 2 returns vblank in bit 7, sprite-zero hit in bit 6, sprite overflow in bit 5 and bus-latch bits 4:0. It then clears the vblank flag and the write toggle. It does not refresh the latch.
- R4: A write to port 5 with the toggle clear sets fine X from data 2:0 and temporary bits 4:0 from data 7:3. With the toggle set, it puts data 2:0 into temporary bits 14:12 and data 7:3 into bits 9:5. Every port 5 or port 6 write inverts the toggle.
- R5: A write to port 6 with the toggle clear puts data 5:0 into temporary bits 13:8 and clears bit 14. With the toggle set, it puts data into bits 7:0 and copies the whole resulting temporary address into the current address.
- R6: When the current address bits 13:8 are not 0x3F, a port 7 read returns the buffered byte. It then loads the buffer with the video-memory byte at the current address.
- R7: When current address bits 13:8 equal 0x3F, a port 7 read returns the fetched byte's bits 5:0 with bus-latch bits 7:6 above them. The buffer is still loaded with the full fetched byte.
- R8: Every completed port 7 access adds 32 to the 15-bit current address when control bit 2 is set, and adds 1 otherwise.
- R9: A port 3 write sets the sprite pointer. A port 4 write stores the byte at the pointer and then increments the pointer. A port 4 read returns the byte at the pointer, ANDed with 0xE3 when pointer bits 1:0 equal 2, and leaves the pointer unchanged.
- R10: The bus latch is refreshed by every write with the written byte and by port 4 and port 7 reads with the returned byte. Reads of ports 0, 1, 3, 5 and 6 return the latch. The latch clears to zero once DECAY_CYCLES clock edges pass without a refresh.
- R11: `cpu_ack` is high for exactly one cycle per request. `vm_req` stays high with a stable `vm_addr` until `vm_ack`. For reads, `cpu_rdata` is valid while `cpu_ack` is high.
- R12: `vbl_set`, `spr0_set` and `ovf_set` set their flags, and `flags_clr` clears all three and wins over the sets. A status read that executes in the same cycle as `vbl_set` returns the old vblank value and leaves the flag clear.
- R13: A port 7 write sends the data byte to video memory at the current address with `vm_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until acknowledge |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_port | input | 3 | Port number 0..7 |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion |
| vbl_set | input | 1 | Renderer: vertical blank begins |
| spr0_set | input | 1 | Renderer: sprite-zero hit |
| ovf_set | input | 1 | Renderer: sprite overflow |
| flags_clr | input | 1 | Renderer: clear all status flags |
| vm_req | output | 1 | Video-memory request |
| vm_we | output | 1 | Video-memory write |
| vm_addr | output | 14 | Video-memory address |
| vm_wdata | output | 8 | Video-memory write data |
| vm_rdata | input | 8 | Video-memory read data, valid with vm_ack |
| vm_ack | input | 1 | Video-memory acknowledge |
| ctrl_o | output | 8 | Control register |
| mask_o | output | 8 | Mask register |
| tmp_addr_o | output | 15 | Temporary address |
| cur_addr_o | output | 15 | Current video-memory address |
| fine_x_o | output | 3 | Fine horizontal offset |

## Verification
The hardest situations to reach from the ports are the ones where bus-latch bits meet the data:

- a palette read, whose top bits come from the latch;
- a status or write-only-port read taken close to the decay limit.

Both depend on how long ago the last refresh happened. The stimulus steers port 6 toward high byte 0x3F to land in the palette region. Random memory latency and random access mixes spread refresh ages across the decay boundary. The bench tracks each refresh edge and compares latch bits only when the age is clearly inside or outside the window. A directed case lines up `vbl_set` with the edge where the status read executes.

// File: rtl/vr_pkg.sv
package vr_pkg;
    localparam int DW     = 8;
    localparam int AW     = 15;
    localparam int VMW    = 14;
    localparam int PW     = 3;
    localparam int SPR_AW = 8;

    localparam logic [PW-1:0] P_CTRL   = 3'd0;
    localparam logic [PW-1:0] P_MASK   = 3'd1;
    localparam logic [PW-1:0] P_STATUS = 3'd2;
    localparam logic [PW-1:0] P_SPRPTR = 3'd3;
    localparam logic [PW-1:0] P_SPRDAT = 3'd4;
    localparam logic [PW-1:0] P_SCROLL = 3'd5;
    localparam logic [PW-1:0] P_ADDR   = 3'd6;
    localparam logic [PW-1:0] P_DATA   = 3'd7;

    localparam logic [5:0] PAL_PAGE = 6'h3F;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VMEM = 2'd1,
        ST_DONE = 2'd2
    } vr_state_t;
endpackage

// File: rtl/vr_scroll_regs.sv
module vr_scroll_regs
    import vr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] port,
    input  logic [DW-1:0] wdata,
    input  logic          tog_clr,
    input  logic          inc_en,
    input  logic          inc_wide,
    output logic [AW-1:0] tmp_addr,
    output logic [AW-1:0] cur_addr,
    output logic [2:0]    fine_x
);
    logic toggle;
    logic [AW-1:0] step;

    assign step = inc_wide ? AW'(32) : AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_addr <= '0;
            cur_addr <= '0;
            fine_x   <= '0;
            toggle   <= 1'b0;
        end else begin
            if (tog_clr) toggle <= 1'b0;
            if (wr_en) begin
                unique case (port)
                    P_CTRL: tmp_addr[11:10] <= wdata[1:0];
                    P_SCROLL: begin
                        if (!toggle) begin
                            fine_x        <= wdata[2:0];
                            tmp_addr[4:0] <= wdata[7:3];
                        end else begin
                            tmp_addr[14:12] <= wdata[2:0];
                            tmp_addr[9:5]   <= wdata[7:3];
                        end
                        toggle <= ~toggle;
                    end
                    P_ADDR: begin
                        if (!toggle) begin
                            tmp_addr[14]   <= 1'b0;
                            tmp_addr[13:8] <= wdata[5:0];
                        end else begin
                            tmp_addr[7:0] <= wdata;
                            cur_addr      <= {tmp_addr[14:8], wdata};
                        end
                        toggle <= ~toggle;
                    end
                    default: ;
                endcase
            end
            if (inc_en) cur_addr <= cur_addr + step;
        end
    end
endmodule

// File: rtl/vr_sprite_mem.sv
module vr_sprite_mem
    import vr_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              data_we,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rd_data,
    output logic [SPR_AW-1:0] ptr
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] raw;

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (ptr_we) ptr <= wdata[SPR_AW-1:0];
        else if (data_we) ptr <= ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (data_we) mem[ptr] <= wdata;
    end

    always_comb begin
        raw     = mem[ptr];
        rd_data = (ptr[1:0] == 2'd2) ? (raw & 8'hE3) : raw;
    end
endmodule

// File: rtl/vr_open_bus.sv
module vr_open_bus
    import vr_pkg::*;
#(
    parameter int DECAY_CYCLES = 65535
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          refresh,
    input  logic [DW-1:0] refresh_val,
    output logic [DW-1:0] latch
);
    localparam int TW = $clog2(DECAY_CYCLES + 1);
    logic [TW-1:0] timer;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= '0;
            timer <= '0;
        end else if (refresh) begin
            latch <= refresh_val;
            timer <= TW'(DECAY_CYCLES);
        end else if (timer != '0) begin
            timer <= timer - 1'b1;
            if (timer == TW'(1)) latch <= '0;
        end
    end
endmodule

// File: rtl/vid_regport.sv
module vid_regport
    import vr_pkg::*;
#(
    parameter int DECAY_CYCLES = 65535,
    parameter int SPR_DEPTH    = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [2:0]     cpu_port,
    input  logic [7:0]     cpu_wdata,
    output logic [7:0]     cpu_rdata,
    output logic           cpu_ack,
    input  logic           vbl_set,
    input  logic           spr0_set,
    input  logic           ovf_set,
    input  logic           flags_clr,
    output logic           vm_req,
    output logic           vm_we,
    output logic [13:0]    vm_addr,
    output logic [7:0]     vm_wdata,
    input  logic [7:0]     vm_rdata,
    input  logic           vm_ack,
    output logic [7:0]     ctrl_o,
    output logic [7:0]     mask_o,
    output logic [14:0]    tmp_addr_o,
    output logic [14:0]    cur_addr_o,
    output logic [2:0]     fine_x_o
);
    vr_state_t state_q, state_d;

    logic [DW-1:0] ctrl_q, mask_q, rbuf_q, rdata_q, wdata_q;
    logic          we_q;
    logic          f_vbl, f_spr0, f_ovf;
    logic [DW-1:0] ob_latch, spr_rd, ob_val, exec_val, vm_ret;
    logic          exec, vm_start, vm_done, reg_wr, stat_rd, spr_rd_en;
    logic          ob_refresh, is_pal;
    logic [SPR_AW-1:0] spr_ptr;

    // Decode
    assign exec      = (state_q == ST_IDLE) && cpu_req && (cpu_port != P_DATA);
    assign vm_start  = (state_q == ST_IDLE) && cpu_req && (cpu_port == P_DATA);
    assign vm_done   = (state_q == ST_VMEM) && vm_ack;
    assign reg_wr    = exec && cpu_we;
    assign stat_rd   = exec && !cpu_we && (cpu_port == P_STATUS);
    assign spr_rd_en = exec && !cpu_we && (cpu_port == P_SPRDAT);
    assign is_pal    = (cur_addr_o[13:8] == PAL_PAGE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (exec) state_d = ST_DONE;
                     else if (vm_start) state_d = ST_VMEM;
            ST_VMEM: if (vm_ack) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        cpu_ack = 1'b0;
        vm_req  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VMEM: vm_req  = 1'b1;
            ST_DONE: cpu_ack = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;
    assign vm_we     = we_q;
    assign vm_wdata  = wdata_q;
    assign vm_addr   = cur_addr_o[VMW-1:0];

    // Read value muxes
    assign ob_val = ob_latch;
    always_comb begin
        unique case (cpu_port)
            P_STATUS: exec_val = {f_vbl, f_spr0, f_ovf, ob_val[4:0]};
            P_SPRDAT: exec_val = spr_rd;
            default:  exec_val = ob_val;
        endcase
    end
    assign vm_ret = is_pal ? {ob_val[7:6], vm_rdata[5:0]} : rbuf_q;

    // Bus latch refresh sources
    logic [DW-1:0] ob_new;
    always_comb begin
        ob_refresh = 1'b0;
        ob_new     = cpu_wdata;
        if ((state_q == ST_IDLE) && cpu_req && cpu_we) begin
            ob_refresh = 1'b1;
            ob_new     = cpu_wdata;
        end else if (spr_rd_en) begin
            ob_refresh = 1'b1;
            ob_new     = spr_rd;
        end else if (vm_done && !we_q) begin
            ob_refresh = 1'b1;
            ob_new     = vm_ret;
        end
    end

    // Registers owned by the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            rbuf_q  <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else begin
            if (reg_wr && cpu_port == P_CTRL) ctrl_q <= cpu_wdata;
            if (reg_wr && cpu_port == P_MASK) mask_q <= cpu_wdata;
            if (exec) rdata_q <= cpu_we ? cpu_wdata : exec_val;
            if (vm_start) begin
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
            end
            if (vm_done) begin
                if (!we_q) begin
                    rdata_q <= vm_ret;
                    rbuf_q  <= vm_rdata;
                end else begin
                    rdata_q <= wdata_q;
                end
            end
        end
    end

    // Status flags: clear-all beats sets, status read beats vblank set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_vbl  <= 1'b0;
            f_spr0 <= 1'b0;
            f_ovf  <= 1'b0;
        end else if (flags_clr) begin
            f_vbl  <= 1'b0;
            f_spr0 <= 1'b0;
            f_ovf  <= 1'b0;
        end else begin
            if (spr0_set) f_spr0 <= 1'b1;
            if (ovf_set)  f_ovf  <= 1'b1;
            if (stat_rd)      f_vbl <= 1'b0;
            else if (vbl_set) f_vbl <= 1'b1;
        end
    end

    assign ctrl_o = ctrl_q;
    assign mask_o = mask_q;

    vr_scroll_regs u_scroll (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .port     (cpu_port),
        .wdata    (cpu_wdata),
        .tog_clr  (stat_rd),
        .inc_en   (vm_done),
        .inc_wide (ctrl_q[2]),
        .tmp_addr (tmp_addr_o),
        .cur_addr (cur_addr_o),
        .fine_x   (fine_x_o)
    );

    vr_sprite_mem #(.DEPTH(SPR_DEPTH)) u_spr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_we  (reg_wr && cpu_port == P_SPRPTR),
        .data_we (reg_wr && cpu_port == P_SPRDAT),
        .wdata   (cpu_wdata),
        .rd_data (spr_rd),
        .ptr     (spr_ptr)
    );

    vr_open_bus #(.DECAY_CYCLES(DECAY_CYCLES)) u_ob (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh     (ob_refresh),
        .refresh_val (ob_new),
        .latch       (ob_latch)
    );
endmodule

// File: rtl/vr_regport_chk.sv
module vr_regport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_ack,
    input logic [5:0]  cpu_rdata_lo,
    input logic        vm_req,
    input logic        vm_ack,
    input logic        vm_we,
    input logic [13:0] vm_addr,
    input logic [5:0]  vm_rdata_lo,
    input logic [14:0] cur_addr,
    input logic        ctrl_wide
);
    p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    p_vmreq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_req && !vm_ack) |=> (vm_req && $stable(vm_addr)));

    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_req && vm_ack) |=>
        (15'(cur_addr - $past(cur_addr)) == ($past(ctrl_wide) ? 15'd32 : 15'd1)));

    p_palette_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_req && vm_ack && !vm_we && vm_addr[13:8] == 6'h3F) |=>
        (cpu_ack && cpu_rdata_lo == $past(vm_rdata_lo)));

    p_ack_after_vm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vm_req && vm_ack) |=> (cpu_ack && !vm_req));
endmodule

bind vid_regport vr_regport_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_ack      (cpu_ack),
    .cpu_rdata_lo (cpu_rdata[5:0]),
    .vm_req       (vm_req),
    .vm_ack       (vm_ack),
    .vm_we        (vm_we),
    .vm_addr      (vm_addr),
    .vm_rdata_lo  (vm_rdata[5:0]),
    .cur_addr     (cur_addr_o),
    .ctrl_wide    (ctrl_o[2])
);

// File: tb/sim_vid_regport.sv
module sim_vid_regport;
    localparam int DECAY = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [2:0] cpu_port = '0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ack;
    logic vbl_set = 1'b0, spr0_set = 1'b0, ovf_set = 1'b0, flags_clr = 1'b0;
    logic vm_req, vm_we;
    logic [13:0] vm_addr;
    logic [7:0] vm_wdata;
    logic [7:0] vm_rdata = '0;
    logic vm_ack = 1'b0;
    logic [7:0] ctrl_o, mask_o;
    logic [14:0] tmp_addr_o, cur_addr_o;
    logic [2:0] fine_x_o;

    always #10 clk = ~clk;

    vid_regport #(.DECAY_CYCLES(DECAY)) u0 (.*);

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Video memory stand-in (aliased on low 10 address bits)
    logic [7:0] bmem [1024];
    int dly = 0;
    always @(negedge clk) begin
        if (vm_ack) vm_ack = 1'b0;
        else if (vm_req) begin
            if (dly == 0) begin
                vm_ack   = 1'b1;
                vm_rdata = bmem[vm_addr[9:0]];
                if (vm_we) bmem[vm_addr[9:0]] = vm_wdata;
                dly = $urandom % 3;
            end else dly--;
        end
    end

    // Reference model state
    logic [7:0]  m_ctrl = 0, m_mask = 0, m_buf = 0, m_ob = 0, m_oa = 0;
    logic [14:0] m_t = 0, m_v = 0;
    logic [2:0]  m_fx = 0;
    logic        m_tog = 0, m_vbl = 0, m_s0 = 0, m_ov = 0, m_fuzzy = 0;
    logic [7:0]  m_oam [256];
    int last_ref = -100000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input logic [31:0] msk);
        checks++;
        if ((act & msk) !== (exp & msk)) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h mask=%0h", tag, act, exp, msk);
        end
    endtask

    // Apply one access to the model and compare the returned byte
    task automatic model(input bit we, input logic [2:0] p, input logic [7:0] d,
                         input logic [7:0] r, input int x);
        int age = x - last_ref;
        bit known = !m_fuzzy && ((age < DECAY - 6) || (age > DECAY + 6));
        logic [7:0] ob = (age <= DECAY) ? m_ob : 8'h00;
        logic [7:0] e, mem;
        if (we) begin
            case (p)
                3'd0: begin m_ctrl = d; m_t[11:10] = d[1:0]; end
                3'd1: m_mask = d;
                3'd3: m_oa = d;
                3'd4: begin m_oam[m_oa] = d; m_oa = m_oa + 1; end
                3'd5: begin
                    if (!m_tog) begin m_fx = d[2:0]; m_t[4:0] = d[7:3]; end
                    else begin m_t[14:12] = d[2:0]; m_t[9:5] = d[7:3]; end
                    m_tog = ~m_tog;
                end
                3'd6: begin
                    if (!m_tog) begin m_t[14] = 0; m_t[13:8] = d[5:0]; end
                    else begin m_t[7:0] = d; m_v = m_t; end
                    m_tog = ~m_tog;
                end
                3'd7: begin
                    chk("R13 written memory byte", bmem[m_v[9:0]], d, 8'hFF);
                    m_v = m_v + (m_ctrl[2] ? 15'd32 : 15'd1);
                end
                default: ;
            endcase
            m_ob = d; last_ref = x; m_fuzzy = 0;
        end else begin
            case (p)
                3'd2: begin
                    e = {m_vbl, m_s0, m_ov, ob[4:0]};
                    chk("R3 status read", r, e, known ? 8'hFF : 8'hE0);
                    m_vbl = 0; m_tog = 0;
                end
                3'd4: begin
                    e = m_oam[m_oa] & ((m_oa[1:0] == 2'd2) ? 8'hE3 : 8'hFF);
                    chk("R9 sprite read", r, e, 8'hFF);
                    m_ob = e; last_ref = x; m_fuzzy = 0;
                end
                3'd7: begin
                    mem = bmem[m_v[9:0]];
                    if (m_v[13:8] == 6'h3F) begin
                        e = {ob[7:6], mem[5:0]};
                        chk("R7 palette read", r, e, known ? 8'hFF : 8'h3F);
                        if (!known) m_fuzzy = 1;
                    end else begin
                        e = m_buf;
                        chk("R6 buffered read", r, e, 8'hFF);
                    end
                    m_buf = mem; m_ob = e; last_ref = x;
                    m_v = m_v + (m_ctrl[2] ? 15'd32 : 15'd1);
                end
                default: chk("R10 open-bus read", r, ob, known ? 8'hFF : 8'h00);
            endcase
        end
        chk("R2 ctrl", ctrl_o, m_ctrl, 8'hFF);
        chk("R2 mask", mask_o, m_mask, 8'hFF);
        chk("R4 tmp addr", tmp_addr_o, m_t, 15'h7FFF);
        chk("R4 fine x", fine_x_o, m_fx, 3'h7);
        chk("R5 R8 cur addr", cur_addr_o, m_v, 15'h7FFF);
    endtask

    task automatic acc(input bit we, input logic [2:0] p, input logic [7:0] d,
                       input bit with_vbl = 0);
        int n = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_port = p; cpu_wdata = d; vbl_set = with_vbl;
        do begin
            @(negedge clk);
            vbl_set = 0;
            n++;
        end while (!cpu_ack && n < 50);
        if (!cpu_ack) begin
            errors++; checks++;
            $display("FAIL R11 no acknowledge actual=0 expected=1");
        end
        cpu_req = 0;
        model(we, p, d, cpu_rdata, cyc);
        @(negedge clk);
        chk("R11 ack one cycle", cpu_ack, 0, 1);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: vbl_set = 1;
            1: spr0_set = 1;
            2: ovf_set = 1;
            default: flags_clr = 1;
        endcase
        @(negedge clk);
        vbl_set = 0; spr0_set = 0; ovf_set = 0; flags_clr = 0;
        case (which)
            0: m_vbl = 1;
            1: m_s0 = 1;
            2: m_ov = 1;
            default: begin m_vbl = 0; m_s0 = 0; m_ov = 0; end
        endcase
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) bmem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_o, 0, 8'hFF);
        chk("R1 cur addr", cur_addr_o, 0, 15'h7FFF);
        chk("R1 tmp addr", tmp_addr_o, 0, 15'h7FFF);
        chk("R1 ack/req", {cpu_ack, vm_req}, 0, 2'h3);
        acc(0, 3'd2, 0);                         // R1 R3 flags and latch zero
        // R9: fill sprite memory
        acc(1, 3'd3, 8'h00);
        for (int i = 0; i < 256; i++) acc(1, 3'd4, 8'(i * 7 + 1));
        acc(1, 3'd3, 8'h06); acc(0, 3'd4, 0);    // byte 2 of entry: masked
        acc(1, 3'd3, 8'h05); acc(0, 3'd4, 0);
        // R2 control and name-table bits
        acc(1, 3'd0, 8'h03); acc(1, 3'd1, 8'hA5);
        // R3 / R12 flags
        pulse(0); pulse(1); acc(0, 3'd2, 0); acc(0, 3'd2, 0);
        pulse(2); pulse(3); acc(0, 3'd2, 0);
        // R4 scroll pair, with toggle reset by status read
        acc(1, 3'd5, 8'h7D); acc(0, 3'd2, 0); acc(1, 3'd5, 8'h7D); acc(1, 3'd5, 8'h5E);
        // R5 R7 palette region
        acc(1, 3'd6, 8'hFF); acc(1, 3'd6, 8'h00); acc(0, 3'd7, 0); acc(0, 3'd7, 0);
        // R6 buffered reads, R8 step of 1 then 32
        acc(1, 3'd6, 8'h21); acc(1, 3'd6, 8'h08); acc(0, 3'd7, 0); acc(0, 3'd7, 0);
        acc(1, 3'd0, 8'h04); acc(0, 3'd7, 0); acc(1, 3'd7, 8'h9C);
        acc(1, 3'd6, 8'h21); acc(1, 3'd6, 8'h28); acc(0, 3'd7, 0); acc(0, 3'd7, 0);
        // R10 decay
        acc(1, 3'd1, 8'hF7); repeat (20) @(negedge clk); acc(0, 3'd0, 0);
        repeat (DECAY + 20) @(negedge clk); acc(0, 3'd5, 0); acc(0, 3'd2, 0);
        // R12 status read coinciding with vblank set
        pulse(0); acc(0, 3'd2, 0, 1); acc(0, 3'd2, 0);
        // Random mix
        for (int k = 0; k < 1500; k++) begin
            logic [2:0] p = 3'($urandom % 8);
            bit we = $urandom % 2;
            logic [7:0] d = 8'($urandom);
            if (p == 3'd2 || p == 3'd6) we = (p == 3'd6) ? 1 : we;
            if (p == 3'd6 && !m_tog && ($urandom % 2)) d = 8'h3F;
            if ($urandom % 10 == 0) pulse($urandom % 4);
            if ($urandom % 25 == 0) repeat ($urandom % 80) @(negedge clk);
            acc(we, p, d);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule